// File: doc/BRIEF.md
# Microcoded Shift-Add Multiplier Sequencer

This block sequences a shift-add multiplier datapath. Its whole state is one address register. That register selects a word from a fixed, combinational control store. Each word carries four control bits for the datapath, a selector naming which status input (if any) is tested, and two successor addresses. The successor is used when the tested input is 1 or when nothing is tested; the alternate address is used when the tested input is 0. All outputs come from the stored word alone, so they depend only on the address register and never directly on the status inputs.

The microprogram has five states: idle, initialise, test-multiplier-bit, add, and shift. A start request moves the sequencer out of idle. It then clears the datapath and loops through test, optional add, and shift until the datapath reports that its iteration counter has reached zero. It then returns to idle. No word tests more than one status input.

Top module: `mpc_ctrl_top`

## Requirements
- R1: An active-low asynchronous reset forces the sequencer into the idle state at once. While reset is low, all four outputs are low.
- R2: In idle, all outputs are low. At a rising edge with go_i=1 the sequencer enters the initialise state; with go_i=0 it stays in idle.
- R3: In the initialise state, init_o and clr_carry_o are high and load_o and shift_o are low. The next edge always moves it to the test state.
- R4: In the test state, all outputs are low. At the next edge it enters the add state if mplr_lsb_i=1 and the shift state if mplr_lsb_i=0.
- R5: In the add state, only load_o is high. The next edge always moves it to the shift state.
- R6: In the shift state, shift_o and clr_carry_o are high and init_o and load_o are low. At the next edge it returns to idle if cnt_zero_i=1 and goes back to the test state otherwise.
- R7: Outputs are a function of the address register only. A change on any status input between clock edges leaves all outputs unchanged in that cycle.
- R8: A status input that the current state does not test has no effect on the next state. This covers go_i outside idle, mplr_lsb_i outside the test state, and cnt_zero_i outside the shift state.
- R9: At most one of init_o, load_o and shift_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the address register updates on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start request from the environment |
| mplr_lsb_i | input | 1 | Least significant bit of the multiplier operand register |
| cnt_zero_i | input | 1 | Datapath iteration counter has reached zero |
| init_o | output | 1 | Load the operands and clear the partial product |
| clr_carry_o | output | 1 | Clear the carry flip-flop |
| load_o | output | 1 | Add the multiplicand into the partial product |
| shift_o | output | 1 | Shift carry, partial product and multiplier right; decrement the counter |

## Verification
The end-of-iteration decision in the shift state can coincide with a new start request. To provoke this, go_i is held high through an entire multiply, so it is present in the cycle where cnt_zero_i ends the loop. The reference model expects the request to be ignored there: exactly one idle cycle with all outputs low, then the initialise state. A second coincidence pairs an input change inside a cycle with a state's outputs. Every status input is inverted between edges and the outputs are checked again before the clock rises.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    COND_NONE = 2'd0,
    COND_GO   = 2'd1,
    COND_LSB  = 2'd2,
    COND_ZERO = 2'd3
  } cond_e;

  typedef struct packed {
    logic init;
    logic clr;
    logic load;
    logic shift;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // nxt_t: taken when condition is 1 or none is tested; nxt_f otherwise
  typedef struct packed {
    ctrl_t ctrl;
    cond_e cond;
    addr_t nxt_t;
    addr_t nxt_f;
  } uinstr_t;

  localparam addr_t A_IDLE  = addr_t'(0);
  localparam addr_t A_INIT  = addr_t'(1);
  localparam addr_t A_TEST  = addr_t'(2);
  localparam addr_t A_ADD   = addr_t'(3);
  localparam addr_t A_SHIFT = addr_t'(4);

  function automatic uinstr_t uprog_word(addr_t a);
    uinstr_t w;
    w = '0;
    w.cond  = COND_NONE;
    w.nxt_t = A_IDLE;
    w.nxt_f = A_IDLE;
    case (a)
      A_IDLE: begin
        w.cond  = COND_GO;
        w.nxt_t = A_INIT;
        w.nxt_f = A_IDLE;
      end
      A_INIT: begin
        w.ctrl.init = 1'b1;
        w.ctrl.clr  = 1'b1;
        w.nxt_t     = A_TEST;
        w.nxt_f     = A_TEST;
      end
      A_TEST: begin
        w.cond  = COND_LSB;
        w.nxt_t = A_ADD;
        w.nxt_f = A_SHIFT;
      end
      A_ADD: begin
        w.ctrl.load = 1'b1;
        w.nxt_t     = A_SHIFT;
        w.nxt_f     = A_SHIFT;
      end
      A_SHIFT: begin
        w.ctrl.shift = 1'b1;
        w.ctrl.clr   = 1'b1;
        w.cond       = COND_ZERO;
        w.nxt_t      = A_IDLE;
        w.nxt_f      = A_TEST;
      end
      default: ; // unused words: no outputs, back to idle
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mpc_addr_reg.sv
module mpc_addr_reg
  import mpc_pkg::*;
#(
  parameter addr_t RST_ADDR = A_IDLE
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  addr_t nxt_i,
  output addr_t addr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_o <= RST_ADDR;
    else         addr_o <= nxt_i;
  end

endmodule

// File: rtl/mpc_ctrl_mem.sv
module mpc_ctrl_mem
  import mpc_pkg::*;
#(
  parameter int unsigned WORDS = DEPTH
) (
  input  addr_t   addr_i,
  output uinstr_t word_o
);

  uinstr_t rom [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign rom[i] = uprog_word(addr_t'(i));
  end

  assign word_o = rom[addr_i];

endmodule

// File: rtl/mpc_next_addr.sv
module mpc_next_addr
  import mpc_pkg::*;
(
  input  cond_e cond_i,
  input  addr_t nxt_t_i,
  input  addr_t nxt_f_i,
  input  logic  go_i,
  input  logic  mplr_lsb_i,
  input  logic  cnt_zero_i,
  output addr_t nxt_o
);

  logic take_t;

  always_comb begin
    unique case (cond_i)
      COND_GO:   take_t = go_i;
      COND_LSB:  take_t = mplr_lsb_i;
      COND_ZERO: take_t = cnt_zero_i;
      default:   take_t = 1'b1;
    endcase
  end

  assign nxt_o = take_t ? nxt_t_i : nxt_f_i;

endmodule

// File: rtl/mpc_ctrl_top.sv
module mpc_ctrl_top
  import mpc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic mplr_lsb_i,
  input  logic cnt_zero_i,
  output logic init_o,
  output logic clr_carry_o,
  output logic load_o,
  output logic shift_o
);

  addr_t   addr_q;
  addr_t   addr_d;
  uinstr_t word;

  mpc_addr_reg #(
    .RST_ADDR (A_IDLE)
  ) u_areg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (addr_d),
    .addr_o (addr_q)
  );

  mpc_ctrl_mem #(
    .WORDS (DEPTH)
  ) u_mem (
    .addr_i (addr_q),
    .word_o (word)
  );

  mpc_next_addr u_nxt (
    .cond_i     (word.cond),
    .nxt_t_i    (word.nxt_t),
    .nxt_f_i    (word.nxt_f),
    .go_i       (go_i),
    .mplr_lsb_i (mplr_lsb_i),
    .cnt_zero_i (cnt_zero_i),
    .nxt_o      (addr_d)
  );

  assign init_o      = word.ctrl.init;
  assign clr_carry_o = word.ctrl.clr;
  assign load_o      = word.ctrl.load;
  assign shift_o     = word.ctrl.shift;

endmodule

// File: rtl/mpc_ctrl_chk.sv
module mpc_ctrl_chk
  import mpc_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  go_i,
  input logic  mplr_lsb_i,
  input logic  cnt_zero_i,
  input logic  init_o,
  input logic  clr_carry_o,
  input logic  load_o,
  input logic  shift_o,
  input addr_t addr_i
);

  logic [3:0] outs;
  assign outs = {init_o, clr_carry_o, load_o, shift_o};

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (addr_i == A_IDLE && outs == 4'b0000)
        else $error("reset state wrong");
    end
  end

  // R2
  idle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_IDLE && go_i) |=> (init_o && clr_carry_o));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_IDLE && !go_i) |=> (addr_i == A_IDLE && outs == 4'b0000));

  // R3
  init_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> (outs == 4'b0000 && addr_i == A_TEST));

  // R4
  test_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_TEST && mplr_lsb_i) |=> (outs == 4'b0010));

  // R4
  test_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_TEST && !mplr_lsb_i) |=> (outs == 4'b0101));

  // R5
  add_to_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (shift_o && !load_o));

  // R6
  shift_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |-> (clr_carry_o && !init_o && !load_o));

  // R6
  shift_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && cnt_zero_i) |=> (addr_i == A_IDLE));

  // R6
  shift_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && !cnt_zero_i) |=> (addr_i == A_TEST));

  // R7
  moore_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == $past(addr_i)) |-> (outs == $past(outs)));

  // R9
  excl_ops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({init_o, load_o, shift_o}));

endmodule

bind mpc_ctrl_top mpc_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .go_i        (go_i),
  .mplr_lsb_i  (mplr_lsb_i),
  .cnt_zero_i  (cnt_zero_i),
  .init_o      (init_o),
  .clr_carry_o (clr_carry_o),
  .load_o      (load_o),
  .shift_o     (shift_o),
  .addr_i      (addr_q)
);

// File: tb/mpc_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module mpc_ctrl_top_tb_top;

  localparam int S_IDLE = 0, S_INIT = 1, S_TEST = 2, S_ADD = 3, S_SHIFT = 4;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic go_i, mplr_lsb_i, cnt_zero_i;
  logic init_o, clr_carry_o, load_o, shift_o;

  int checks = 0;
  int errors = 0;
  int st = S_IDLE;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mpc_ctrl_top dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go_i),
    .mplr_lsb_i  (mplr_lsb_i),
    .cnt_zero_i  (cnt_zero_i),
    .init_o      (init_o),
    .clr_carry_o (clr_carry_o),
    .load_o      (load_o),
    .shift_o     (shift_o)
  );

  // {init, clr_carry, load, shift}
  function automatic logic [3:0] exp_out(int s);
    case (s)
      S_INIT:  return 4'b1100;
      S_ADD:   return 4'b0010;
      S_SHIFT: return 4'b0101;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic int nxt(int s, logic g, logic l, logic z);
    case (s)
      S_IDLE:  return g ? S_INIT : S_IDLE;
      S_INIT:  return S_TEST;
      S_TEST:  return l ? S_ADD : S_SHIFT;
      S_ADD:   return S_SHIFT;
      S_SHIFT: return z ? S_IDLE : S_TEST;
      default: return S_IDLE;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      S_IDLE:  return "R2";
      S_INIT:  return "R3";
      S_TEST:  return "R4";
      S_ADD:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {init_o, clr_carry_o, load_o, shift_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: outputs %b expected %b", tag, $time, act, exp);
    end
  endtask

  // called just after a negedge; result checked at the following negedge
  task automatic cyc(logic g, logic l, logic z, string tag);
    go_i = g; mplr_lsb_i = l; cnt_zero_i = z;
    @(posedge clk_i);
    st = nxt(st, g, l, z);
    @(negedge clk_i);
    chk(tag, exp_out(st));
  endtask

  // R7: invert status inputs mid-cycle, outputs must hold
  task automatic cyc_wiggle(logic g, logic l, logic z, string tag);
    go_i = ~g; mplr_lsb_i = ~l; cnt_zero_i = ~z;
    #1;
    chk("R7", exp_out(st));
    go_i = g; mplr_lsb_i = l; cnt_zero_i = z;
    #1;
    chk("R7", exp_out(st));
    cyc(g, l, z, tag);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_ni = 1'b0;
    go_i = 1'b0; mplr_lsb_i = 1'b1; cnt_zero_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1", 4'b0000);
    rst_ni = 1'b1;
    st = S_IDLE;

    // idle, unrelated inputs toggling (R8)
    cyc(1'b0, 1'b1, 1'b0, "R8");
    cyc(1'b0, 1'b0, 1'b1, "R8");
    cyc(1'b0, 1'b1, 1'b1, "R2");

    // full multiply, go held high all the way (R8 at the end)
    cyc(1'b1, 1'b0, 1'b0, "R2");   // -> INIT
    cyc(1'b1, 1'b0, 1'b1, "R3");   // -> TEST, lsb/zero ignored
    cyc(1'b1, 1'b1, 1'b1, "R4");   // -> ADD
    cyc(1'b1, 1'b0, 1'b1, "R5");   // -> SHIFT, lsb/zero ignored
    cyc(1'b1, 1'b1, 1'b0, "R6");   // -> TEST
    cyc(1'b1, 1'b0, 1'b1, "R4");   // -> SHIFT
    cyc(1'b1, 1'b1, 1'b1, "R8");   // -> IDLE despite go
    chk("R8", 4'b0000);
    cyc(1'b1, 1'b0, 1'b0, "R2");   // -> INIT

    // mid-cycle input changes in every state (R7)
    cyc_wiggle(1'b0, 1'b1, 1'b0, "R3");
    cyc_wiggle(1'b0, 1'b1, 1'b0, "R4");
    cyc_wiggle(1'b0, 1'b0, 1'b0, "R5");
    cyc_wiggle(1'b0, 1'b0, 1'b0, "R6");
    cyc_wiggle(1'b0, 1'b0, 1'b0, "R4");
    cyc_wiggle(1'b1, 1'b0, 1'b1, "R6");
    cyc_wiggle(1'b0, 1'b0, 1'b0, "R2");

    // asynchronous reset while in the shift state
    cyc(1'b1, 1'b0, 1'b0, "R2");
    cyc(1'b0, 1'b0, 1'b0, "R3");
    cyc(1'b0, 1'b0, 1'b0, "R4");
    chk("R6", 4'b0101);
    go_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R1", 4'b0000);
    st = S_IDLE;
    @(negedge clk_i);
    chk("R1", 4'b0000);
    rst_ni = 1'b1;

    // pseudo-random status stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      string t;
      t = tag_of(st);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], lfsr[3], lfsr[5] & lfsr[7], t);
      if ($countones({init_o, load_o, shift_o}) > 1) begin
        errors++;
        $display("FAIL R9: init/load/shift %b expected at most one high",
                 {init_o, load_o, shift_o});
      end
      checks++;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule